// File: doc/BRIEF.md
# Delayed Read Retry Engine

This block drives the target-bus side of a bridge delayed read. It takes one queued read request at a time from the delayed transaction queue and keeps re-issuing it on the target bus for as long as the target answers with a retry. Once the target claims the cycle and presents data, every word is pushed into the read data queue that faces the bus where the read started. Words are accepted one per clock, with no wait states.

Retried attempts are counted against a programmable limit. When the limit runs out before any data has arrived, the request is dropped and a system-error event is raised. The external error output follows that event only when the error-enable configuration bit is set. The fill ends for any of these reasons:
- the target disconnects;
- the target retries after data has already moved;
- the requested length is reached;
- the destination queue is full.

In each case the queue entry is marked complete.

Top module: `dread_retry_engine`

## Requirements
- R1: Each target retry seen before the first data word counts one attempt against `cfg_retry_limit_i`. A limit value of 0 selects the parameter `LIMIT_DEF`, which defaults to 2^24. The default counter width of 33 bits allows limits up to 2^32.
- R2: The limit-th retried attempt of a request raises `err_event_o` for one cycle, in the cycle after that retry. The request is dropped: `req_ready_o` is high in that same cycle and nothing is pushed.
- R3: `serr_o` pulses together with `err_event_o` only when `cfg_serr_en_i` was high at the exhausting retry. Otherwise `serr_o` stays low.
- R4: The attempt count restarts from zero for every request loaded, so retries of an earlier request never add to a later one.
- R5: A word is accepted only in a cycle where `tgt_issue_o`, `tgt_devsel_i` and `tgt_trdy_i` are high and `tgt_retry_i` is low. A devsel without trdy pushes nothing.
- R6: Each accepted word is pushed one cycle after acceptance. Words accepted on consecutive cycles are pushed on consecutive cycles, with no gaps inserted.
- R7: With `req_dir_i`=0 (downstream), words go to the up queue (`up_*`). With `req_dir_i`=1 (upstream), words go to the down queue (`dn_*`). Both queues never receive a push in the same cycle.
- R8: The fill ends on any of these:
  - a disconnect, where a word offered with trdy in the same cycle is still taken;
  - a retry after data has moved;
  - the word that reaches `req_len_i`, in whose cycle `tgt_stop_o` is high.
  
  The completion pulse of the chosen queue (`up_cmpl_o`/`dn_cmpl_o`) appears in the same cycle as the final push, or in the cycle after the ending response.
- R9: If the chosen queue is full after data has moved, `tgt_stop_o` is high, no word is taken and the fill ends with a completion pulse. If the queue is full before any data has moved, `tgt_issue_o` stays low until room appears.
- R10: After reset `req_ready_o` is high, and `tgt_issue_o`, all push, completion and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Delayed-read request offered |
| req_ready_o | output | 1 | Engine idle, request taken this cycle |
| req_addr_i | input | AW | Read start address |
| req_dir_i | input | 1 | 0 downstream, 1 upstream |
| req_len_i | input | LW | Words wanted (1 or more) |
| cfg_retry_limit_i | input | CNT_W | Attempt limit, 0 selects LIMIT_DEF |
| cfg_serr_en_i | input | 1 | System-error output enable |
| tgt_issue_o | output | 1 | Read attempt driven on target bus |
| tgt_addr_o | output | AW | Address of the attempt |
| tgt_stop_o | output | 1 | Master ends the transfer this cycle |
| tgt_devsel_i | input | 1 | Target claimed the cycle |
| tgt_trdy_i | input | 1 | Target data valid |
| tgt_retry_i | input | 1 | Target retry / termination |
| tgt_disc_i | input | 1 | Target disconnect |
| tgt_data_i | input | DW | Read data word |
| up_full_i | input | 1 | Up queue full |
| up_push_o | output | 1 | Push into up queue |
| up_data_o | output | DW | Up queue data |
| up_cmpl_o | output | 1 | Up queue entry complete |
| dn_full_i | input | 1 | Down queue full |
| dn_push_o | output | 1 | Push into down queue |
| dn_data_o | output | DW | Down queue data |
| dn_cmpl_o | output | 1 | Down queue entry complete |
| err_event_o | output | 1 | Attempt limit exhausted |
| serr_o | output | 1 | Gated system error |

## Verification
The bench builds the engine with `CNT_W`=8, `LIMIT_DEF`=5 and `LW`=4. With these values both exhaustion paths take only a few cycles: the programmed limit and the zero-selects-default limit. The short length field lets the bench reach the end-by-length case, and the last word of a burst, in a handful of beats. The other values keep their full-size widths.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} drr_state_e;
  // queue index equals request direction: downstream read fills the up queue
  localparam int Q_UP = 0;
  localparam int Q_DN = 1;
  localparam int NUM_Q = 2;
endpackage

// File: rtl/drr_attempt_ctr.sv
module drr_attempt_ctr #(
  parameter int CNT_W     = 33,
  parameter longint LIMIT_DEF = 64'd16777216
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] cfg_limit_i,
  output logic             exhaust_o
);
  localparam logic [CNT_W-1:0] DefLim = CNT_W'(LIMIT_DEF);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;

  assign lim       = (cfg_limit_i == '0) ? DefLim : cfg_limit_i;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign exhaust_o = inc_i && (cnt_nxt >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (inc_i && !exhaust_o) cnt_q <= cnt_nxt;
  end

  // R1: the stored count never reaches the active limit
  p_cnt_below_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> cnt_q < lim);
endmodule

// File: rtl/drr_rdq_steer.sv
module drr_rdq_steer
  import drr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 beat_i,
  input  logic                 cmpl_i,
  input  logic                 dir_i,
  input  logic [DW-1:0]        data_i,
  input  logic [NUM_Q-1:0]     full_i,
  output logic                 full_sel_o,
  output logic [NUM_Q-1:0]     push_o,
  output logic [NUM_Q-1:0]     cmpl_o,
  output logic [NUM_Q-1:0][DW-1:0] data_o
);
  assign full_sel_o = full_i[dir_i];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic sel;
    assign sel = (int'(dir_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        push_o[g] <= 1'b0;
        cmpl_o[g] <= 1'b0;
        data_o[g] <= '0;
      end else begin
        push_o[g] <= beat_i && sel;
        cmpl_o[g] <= cmpl_i && sel;
        if (beat_i && sel) data_o[g] <= data_i;
      end
    end

    // R9: no push into a queue that reported full
    p_push_room_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_o[g] |-> $past(!full_i[g]));
  end
endmodule

// File: rtl/drr_ctrl.sv
module drr_ctrl
  import drr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_dir_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          cfg_serr_en_i,
  output logic          tgt_issue_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic          tgt_stop_o,
  input  logic          tgt_devsel_i,
  input  logic          tgt_trdy_i,
  input  logic          tgt_retry_i,
  input  logic          tgt_disc_i,
  input  logic          full_sel_i,
  input  logic          exhaust_i,
  output logic          beat_o,
  output logic          cmpl_o,
  output logic          dir_o,
  output logic          cnt_clear_o,
  output logic          cnt_inc_o,
  output logic          err_o,
  output logic          serr_o
);
  drr_state_e state_q;
  logic          got_q, dir_q;
  logic [LW-1:0] len_q, beats_q;
  logic [AW-1:0] addr_q;
  logic active, last, retry_ev, err_ev, end_ev;

  assign active      = (state_q == ST_ACTIVE);
  assign req_ready_o = !active;
  assign cnt_clear_o = !active;
  assign dir_o       = dir_q;
  assign tgt_addr_o  = addr_q;

  // hold off the attempt while the destination queue has no room for a first word
  assign tgt_issue_o = active && !(full_sel_i && !got_q);
  assign beat_o      = tgt_issue_o && tgt_devsel_i && tgt_trdy_i && !tgt_retry_i && !full_sel_i;
  assign last        = beat_o && (beats_q + 1'b1 == len_q);
  assign retry_ev    = tgt_issue_o && tgt_retry_i && !got_q;
  assign cnt_inc_o   = retry_ev;
  assign err_ev      = retry_ev && exhaust_i;
  assign end_ev      = (beat_o && (tgt_disc_i || last)) ||
                       (tgt_issue_o && got_q && !beat_o && (tgt_retry_i || tgt_disc_i || full_sel_i));
  assign tgt_stop_o  = tgt_issue_o && (last || (got_q && full_sel_i));
  assign cmpl_o      = end_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      got_q   <= 1'b0;
      dir_q   <= 1'b0;
      len_q   <= '0;
      beats_q <= '0;
      addr_q  <= '0;
      err_o   <= 1'b0;
      serr_o  <= 1'b0;
    end else begin
      err_o  <= err_ev;
      serr_o <= err_ev && cfg_serr_en_i;
      if (!active) begin
        if (req_valid_i) begin
          state_q <= ST_ACTIVE;
          got_q   <= 1'b0;
          dir_q   <= req_dir_i;
          len_q   <= req_len_i;
          beats_q <= '0;
          addr_q  <= req_addr_i;
        end
      end else begin
        if (beat_o) begin
          got_q   <= 1'b1;
          beats_q <= beats_q + 1'b1;
        end
        if (end_ev || err_ev) state_q <= ST_IDLE;
      end
    end
  end

  // R2: an exhausted request leaves the engine idle
  p_err_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !active);
endmodule

// File: rtl/dread_retry_engine.sv
module dread_retry_engine
  import drr_pkg::*;
#(
  parameter int     DW        = 32,
  parameter int     AW        = 32,
  parameter int     LW        = 8,
  parameter int     CNT_W     = 33,
  parameter longint LIMIT_DEF = 64'd16777216
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_dir_i,
  input  logic [LW-1:0]    req_len_i,
  input  logic [CNT_W-1:0] cfg_retry_limit_i,
  input  logic             cfg_serr_en_i,
  output logic             tgt_issue_o,
  output logic [AW-1:0]    tgt_addr_o,
  output logic             tgt_stop_o,
  input  logic             tgt_devsel_i,
  input  logic             tgt_trdy_i,
  input  logic             tgt_retry_i,
  input  logic             tgt_disc_i,
  input  logic [DW-1:0]    tgt_data_i,
  input  logic             up_full_i,
  output logic             up_push_o,
  output logic [DW-1:0]    up_data_o,
  output logic             up_cmpl_o,
  input  logic             dn_full_i,
  output logic             dn_push_o,
  output logic [DW-1:0]    dn_data_o,
  output logic             dn_cmpl_o,
  output logic             err_event_o,
  output logic             serr_o
);
  logic beat, cmpl, dir, full_sel, exhaust, cnt_clear, cnt_inc;
  logic [NUM_Q-1:0] full_v, push_v, cmpl_v;
  logic [NUM_Q-1:0][DW-1:0] data_v;

  assign full_v[Q_UP] = up_full_i;
  assign full_v[Q_DN] = dn_full_i;
  assign up_push_o = push_v[Q_UP];
  assign dn_push_o = push_v[Q_DN];
  assign up_cmpl_o = cmpl_v[Q_UP];
  assign dn_cmpl_o = cmpl_v[Q_DN];
  assign up_data_o = data_v[Q_UP];
  assign dn_data_o = data_v[Q_DN];

  drr_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_dir_i, .req_len_i,
    .cfg_serr_en_i, .tgt_issue_o, .tgt_addr_o, .tgt_stop_o, .tgt_devsel_i, .tgt_trdy_i,
    .tgt_retry_i, .tgt_disc_i,
    .full_sel_i(full_sel), .exhaust_i(exhaust), .beat_o(beat), .cmpl_o(cmpl), .dir_o(dir),
    .cnt_clear_o(cnt_clear), .cnt_inc_o(cnt_inc), .err_o(err_event_o), .serr_o(serr_o)
  );

  drr_attempt_ctr #(.CNT_W(CNT_W), .LIMIT_DEF(LIMIT_DEF)) u_ctr (
    .clk_i, .rst_ni, .clear_i(cnt_clear), .inc_i(cnt_inc),
    .cfg_limit_i(cfg_retry_limit_i), .exhaust_o(exhaust)
  );

  drr_rdq_steer #(.DW(DW)) u_steer (
    .clk_i, .rst_ni, .beat_i(beat), .cmpl_i(cmpl), .dir_i(dir), .data_i(tgt_data_i),
    .full_i(full_v), .full_sel_o(full_sel), .push_o(push_v), .cmpl_o(cmpl_v), .data_o(data_v)
  );

  p_serr_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> err_event_o && $past(cfg_serr_en_i));
  p_data_needs_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_push_o || dn_push_o) |-> $past(tgt_devsel_i && tgt_trdy_i && tgt_issue_o));
  p_one_queue_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_push_o, dn_push_o}));
  p_err_no_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_event_o |-> req_ready_o && !up_push_o && !dn_push_o);
endmodule

// File: tb/dread_retry_engine_test.sv
module dread_retry_engine_test;
  localparam int DW = 32, AW = 32, LW = 4, CNT_W = 8;
  localparam longint LIMIT_DEF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_dir = 0;
  logic [AW-1:0] req_addr = '0, tgt_addr;
  logic [LW-1:0] req_len = '0;
  logic [CNT_W-1:0] cfg_lim = '0;
  logic cfg_en = 0;
  logic issue, stop, devsel = 0, trdy = 0, retry = 0, disc = 0;
  logic [DW-1:0] tdata = '0, up_data, dn_data;
  logic up_full = 0, dn_full = 0, up_push, dn_push, up_cmpl, dn_cmpl, err_ev, serr;

  int vectors = 0, fails = 0;
  int up_n, dn_n, upc_n, dnc_n, err_n, serr_n, cyc = 0;
  logic [DW-1:0] up_log [16];
  logic [DW-1:0] dn_log [16];
  int up_cyc [16];

  always #2.5 clk = ~clk;

  dread_retry_engine #(.DW(DW), .AW(AW), .LW(LW), .CNT_W(CNT_W), .LIMIT_DEF(LIMIT_DEF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_dir_i(req_dir), .req_len_i(req_len),
    .cfg_retry_limit_i(cfg_lim), .cfg_serr_en_i(cfg_en),
    .tgt_issue_o(issue), .tgt_addr_o(tgt_addr), .tgt_stop_o(stop),
    .tgt_devsel_i(devsel), .tgt_trdy_i(trdy), .tgt_retry_i(retry), .tgt_disc_i(disc),
    .tgt_data_i(tdata), .up_full_i(up_full), .up_push_o(up_push), .up_data_o(up_data),
    .up_cmpl_o(up_cmpl), .dn_full_i(dn_full), .dn_push_o(dn_push), .dn_data_o(dn_data),
    .dn_cmpl_o(dn_cmpl), .err_event_o(err_ev), .serr_o(serr)
  );

  // monitor: sample registered outputs shortly after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (up_push && up_n < 16) begin up_log[up_n] = up_data; up_cyc[up_n] = cyc; up_n++; end
    if (dn_push && dn_n < 16) begin dn_log[dn_n] = dn_data; dn_n++; end
    if (up_cmpl) upc_n++;
    if (dn_cmpl) dnc_n++;
    if (err_ev) err_n++;
    if (serr) serr_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clr();
    up_n = 0; dn_n = 0; upc_n = 0; dnc_n = 0; err_n = 0; serr_n = 0;
  endtask

  // called at negedge; returns at negedge with engine active
  task automatic start_req(input logic dir, input int len, input int addr);
    req_valid = 1; req_dir = dir; req_len = LW'(len); req_addr = AW'(addr);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
  endtask

  // one target response cycle; exp_stop < 0 skips the stop check
  task automatic resp(input logic d, input logic t, input logic r, input logic x,
                      input int data, input int exp_stop, input string req);
    devsel = d; trdy = t; retry = r; disc = x; tdata = DW'(data);
    #1;
    if (exp_stop >= 0) chk(stop == exp_stop[0], req, stop, exp_stop);
    @(posedge clk); @(negedge clk);
    devsel = 0; trdy = 0; retry = 0; disc = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R10 ready", req_ready, 1);
    chk(issue == 0 && up_push == 0 && dn_push == 0, "R10 quiet", issue, 0);
    chk(err_ev == 0 && serr == 0 && up_cmpl == 0 && dn_cmpl == 0, "R10 err", err_ev, 0);
  endtask

  task automatic t_basic_down();
    mon_clr(); cfg_lim = 3;
    start_req(0, 4, 'h100);
    chk(issue == 1 && tgt_addr == 'h100, "R5 issue", issue, 1);
    resp(1, 0, 0, 0, 'hDEAD, -1, "R5");
    chk(up_n == 0, "R5 devsel without trdy", up_n, 0);
    for (int i = 0; i < 4; i++) resp(1, 1, 0, 0, 'hA0 + i, (i == 3) ? 1 : 0, "R8 stop on last");
    idle(2);
    chk(up_n == 4 && dn_n == 0, "R7 up queue count", up_n, 4);
    for (int i = 0; i < 4; i++) chk(up_log[i] == DW'('hA0 + i), "R6 data", up_log[i], 'hA0 + i);
    chk(up_cyc[3] - up_cyc[0] == 3, "R6 no gaps", up_cyc[3] - up_cyc[0], 3);
    chk(upc_n == 1 && dnc_n == 0, "R8 cmpl", upc_n, 1);
    chk(req_ready == 1 && err_n == 0, "R8 idle after", req_ready, 1);
  endtask

  task automatic t_count_reset();
    mon_clr(); cfg_lim = 3; cfg_en = 1;
    for (int k = 0; k < 2; k++) begin
      start_req(k[0], 1, 'h200);
      resp(0, 0, 1, 0, 0, -1, "R4");
      resp(0, 0, 1, 0, 0, -1, "R4");
      resp(1, 1, 0, 0, 'h55 + k, 1, "R4 last");
    end
    idle(2);
    chk(err_n == 0, "R4 count restarts per request", err_n, 0);
    chk(up_n == 1 && dn_n == 1, "R1 data after retries", up_n + dn_n, 2);
  endtask

  task automatic t_exhaust(input logic en, input int lim);
    mon_clr(); cfg_lim = CNT_W'(lim); cfg_en = en;
    start_req(0, 2, 'h300);
    for (int i = 0; i < lim; i++) resp(0, 0, 1, 0, 0, -1, "R2");
    chk(err_n == 1, "R2 error event", err_n, 1);
    chk(serr_n == (en ? 1 : 0), "R3 serr gating", serr_n, en);
    chk(req_ready == 1 && up_n == 0 && dn_n == 0, "R2 dropped", req_ready, 1);
    idle(2);
    chk(err_n == 1 && issue == 0, "R2 single pulse", err_n, 1);
  endtask

  task automatic t_default_limit();
    mon_clr(); cfg_lim = 0; cfg_en = 1;
    start_req(1, 2, 'h400);
    for (int i = 0; i < 4; i++) resp(0, 0, 1, 0, 0, -1, "R1");
    chk(err_n == 0 && issue == 1, "R1 below default limit", err_n, 0);
    resp(0, 0, 1, 0, 0, -1, "R1");
    chk(err_n == 1 && serr_n == 1, "R1 default limit reached", err_n, 1);
  endtask

  task automatic t_up_disc();
    mon_clr(); cfg_lim = 3;
    start_req(1, 8, 'h500);
    resp(1, 1, 0, 0, 'h11, 0, "R8");
    resp(1, 1, 0, 1, 'h22, 0, "R8 disc");
    idle(2);
    chk(dn_n == 2 && up_n == 0, "R7 down queue", dn_n, 2);
    chk(dn_log[1] == 'h22, "R8 word with disc kept", dn_log[1], 'h22);
    chk(dnc_n == 1 && req_ready == 1, "R8 disc completes", dnc_n, 1);
  endtask

  task automatic t_retry_after_data();
    mon_clr(); cfg_lim = 1;
    start_req(0, 8, 'h600);
    resp(1, 1, 0, 0, 'h33, 0, "R8");
    resp(0, 0, 1, 0, 0, -1, "R8");
    idle(2);
    chk(up_n == 1 && upc_n == 1 && err_n == 0, "R8 retry after data ends fill", upc_n, 1);
  endtask

  task automatic t_full_after();
    mon_clr(); cfg_lim = 3;
    start_req(0, 8, 'h700);
    resp(1, 1, 0, 0, 'h44, 0, "R9");
    up_full = 1;
    resp(1, 1, 0, 0, 'h45, 1, "R9 stop on full");
    up_full = 0;
    idle(2);
    chk(up_n == 1 && upc_n == 1, "R9 full ends fill", up_n, 1);
  endtask

  task automatic t_full_before();
    mon_clr(); cfg_lim = 3; dn_full = 1;
    start_req(1, 1, 'h800);
    chk(issue == 0, "R9 issue held while full", issue, 0);
    idle(3);
    chk(issue == 0 && dn_n == 0, "R9 still held", issue, 0);
    dn_full = 0; #1;
    chk(issue == 1, "R9 issue resumes", issue, 1);
    resp(1, 1, 0, 0, 'h66, 1, "R9");
    idle(2);
    chk(dn_n == 1 && dn_log[0] == 'h66 && dnc_n == 1, "R9 data after room", dn_n, 1);
  endtask

  initial begin
    #(200000 * 5);
    vectors++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    mon_clr();
    idle(3);
    t_reset();
    rst_n = 1;
    idle(2);
    t_reset();
    t_basic_down();
    t_count_reset();
    t_exhaust(1, 3);
    t_exhaust(0, 2);
    t_exhaust(1, 1);
    t_default_limit();
    t_up_disc();
    t_retry_after_data();
    t_full_after();
    t_full_before();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule